// File: doc/BRIEF.md
# I2C Strap-Addressed Register Slave

This block is the serial front end of a small control register bank. It watches the two-wire bus with the system clock and cleans both lines. It recognises bus conditions and claims transfers addressed to one of four 7-bit addresses, which a 2-bit strap selects. Received bytes become register writes. Register contents are fetched one byte at a time and shifted back to the master.

The slave never drives the data line high. It only asserts an active-low pull enable, and the pad outside the block turns that into an open-drain driver. A write transfer carries a pointer byte followed by data bytes. A read transfer returns bytes starting at the stored pointer. The pointer persists across transfers, so a write of the pointer, a repeated START and a read together give random-access reads.

Top module: `i2c_strap_slave`

## Requirements
- R1: Bus conditions are detected on the cleaned lines. SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. While idle and after any STOP, `sda_low_en` is 0.
- R2: The strap `addr_sel` selects the write/read address bytes: 00 gives 9Ah/9Bh, 01 gives 94h/95h, 10 gives 96h/97h and 11 gives 98h/99h. Bits 7..1 of the first byte after a START are the address, sent MSB first, and bit 0 is the direction (1 is read). On a match, SDA is pulled low for the whole 9th clock pulse.
- R3: A first byte that does not match gets no acknowledge. Later bytes are not acknowledged and cause no write until the next START or STOP.
- R4: In a write transfer the first data byte loads the register pointer. Each later byte gives a one-cycle `wr_en` with `wr_addr` equal to the pointer and `wr_data` equal to the byte, after which the pointer increments. Every byte is acknowledged.
- R5: In a read transfer the slave pulses `rd_req` with `rd_addr` equal to the pointer and takes `rd_data` during that same cycle. It sends the byte MSB first. The pointer increments after every byte sent.
- R6: After each read byte the master's 9th bit decides what follows. Low means the next byte is sent. High means the slave releases SDA and waits for a new START or STOP.
- R7: A START during an active transfer (a repeated START) restarts address reception. The register pointer keeps its value.
- R8: A STOP that falls within the same SCL-high pulse as the preceding START is ignored, and address reception continues.
- R9: Any other STOP ends the transfer at once, even in the middle of a byte. Bytes clocked after it without a START are not acknowledged and write nothing.
- R10: `sda_low_en` changes only while SCL is low.
- R11: After reset `sda_low_en`, `wr_en` and `rd_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 2 | Address strap |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_low_en | output | 1 | 1 pulls the data line low |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register written |
| wr_data | output | 8 | Data written |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 8 | Register to be read |
| rd_data | input | 8 | Register contents, valid while rd_req is high |

## Verification
The address match is tried with every strap value, plus a foreign address. This separates a wrong strap table from a slave that acknowledges everything. Writes are sent singly and in bursts, so that the pointer load is told apart from the pointer increment. Reads are placed behind a repeated START and also started fresh after a NACK, which shows that the pointer survives and that it advances on the final byte too. Two STOP patterns are used. A STOP inside the START pulse must be ignored. A STOP in the middle of a byte must abort, and the stray byte clocked after it must have no effect.

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int PTR_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr_sel,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_low_en,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic             rd_req,
  output logic [PTR_W-1:0] rd_addr,
  input  logic [7:0]       rd_data
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK, S_SKIP
  } st_t;

  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic [2:0] scl_h, sda_h;
  logic scl_f, sda_f, scl_p, sda_p;
  logic scl_rise, scl_fall, start_c, stop_c;
  st_t state;
  logic [3:0] cnt;
  logic [7:0] sh, rdbuf;
  logic [PTR_W-1:0] ptr;
  logic ptr_valid, rw, first_pulse, oe, fetch;
  logic [6:0] own;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

  always_comb begin
    case (addr_sel)
      2'b00:   own = 7'h4D;
      2'b01:   own = 7'h4A;
      2'b10:   own = 7'h4B;
      default: own = 7'h4C;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_h  <= '1;
      sda_h  <= '1;
      scl_f  <= 1'b1;
      sda_f  <= 1'b1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_in};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_in};
      scl_h  <= {scl_h[1:0], scl_sy[SYNC_STAGES-1]};
      sda_h  <= {sda_h[1:0], sda_sy[SYNC_STAGES-1]};
      scl_f  <= maj3(scl_h);
      sda_f  <= maj3(sda_h);
      scl_p  <= scl_f;
      sda_p  <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_c  = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_c   = scl_f & scl_p & ~sda_p & sda_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      sh          <= '0;
      rdbuf       <= '0;
      ptr         <= '0;
      ptr_valid   <= 1'b0;
      rw          <= 1'b0;
      first_pulse <= 1'b0;
      oe          <= 1'b0;
      fetch       <= 1'b0;
      wr_en       <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
    end else begin
      wr_en <= 1'b0;
      fetch <= 1'b0;
      if (fetch) rdbuf <= rd_data;
      if (scl_fall) first_pulse <= 1'b0;
      if (start_c) begin
        state       <= S_ADDR;
        cnt         <= '0;
        oe          <= 1'b0;
        first_pulse <= 1'b1;
        ptr_valid   <= 1'b0;
      end else if (stop_c && !first_pulse) begin
        state <= S_IDLE;
        oe    <= 1'b0;
      end else begin
        case (state)
          S_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (sh[7:1] == own) begin
                oe    <= 1'b1;
                rw    <= sh[0];
                fetch <= sh[0];
                state <= S_AACK;
              end else begin
                state <= S_SKIP;
              end
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                sh    <= rdbuf;
                oe    <= ~rdbuf[7];
                state <= S_RD;
              end else begin
                oe    <= 1'b0;
                state <= S_WR;
              end
            end
          end
          S_WR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              oe    <= 1'b1;
              state <= S_WACK;
              if (!ptr_valid) begin
                ptr       <= sh[PTR_W-1:0];
                ptr_valid <= 1'b1;
              end else begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= sh;
                ptr     <= ptr + 1'b1;
              end
            end
          end
          S_WACK: begin
            if (scl_fall) begin
              oe    <= 1'b0;
              cnt   <= '0;
              state <= S_WR;
            end
          end
          S_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                oe    <= 1'b0;
                state <= S_RACK;
              end else begin
                oe <= ~sh[6];
                sh <= {sh[6:0], 1'b0};
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              ptr <= ptr + 1'b1;
              if (!sda_f) fetch <= 1'b1;
              else        state <= S_SKIP;
            end else if (scl_fall) begin
              cnt   <= '0;
              sh    <= rdbuf;
              oe    <= ~rdbuf[7];
              state <= S_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_low_en = oe;
  assign rd_req     = fetch;
  assign rd_addr    = ptr;

endmodule

// File: rtl/i2c_strap_slave_chk.sv
module i2c_strap_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_low_en,
  input logic       scl_f,
  input logic       wr_en,
  input logic       rd_req,
  input logic [2:0] state
);

  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low_en) |-> !scl_f);

  assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_rdreq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  assert_no_wr_during_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !wr_en);

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0) |-> !sda_low_en);

  assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd7) |-> (!sda_low_en && !wr_en && !rd_req));

endmodule

bind i2c_strap_slave i2c_strap_slave_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sda_low_en (sda_low_en),
  .scl_f      (scl_f),
  .wr_en      (wr_en),
  .rd_req     (rd_req),
  .state      (state)
);

// File: tb/test_i2c_strap_slave.sv
module test_i2c_strap_slave;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] addr_sel = 2'b00;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_bus;
  logic sda_low_en, wr_en, rd_req;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [15:0] exp_wr [$];
  int errors = 0, checks = 0, r10_viol = 0;
  bit done = 0;
  string quiet_req = "R4";
  logic prev_oe = 1'b0;
  logic [7:0] waddr [4] = '{8'h9A, 8'h94, 8'h96, 8'h98};

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_low_en;
  assign rd_data = mem[rd_addr];

  i2c_strap_slave i_i2c_strap_slave (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
    .scl_in(scl_m), .sda_in(sda_bus), .sda_low_en(sda_low_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_low_en !== prev_oe && scl_m) r10_viol++;
      prev_oe <= sda_low_en;
      if (wr_en) begin
        mem[wr_addr] <= wr_data;
        if (exp_wr.size() == 0) begin
          check(0, quiet_req, {wr_addr, wr_data}, 0);
        end else begin
          logic [15:0] e;
          e = exp_wr.pop_front();
          check({wr_addr, wr_data} == e, "R4", {wr_addr, wr_data}, e);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic do_bit(input logic b, output logic s);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    s = sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) do_bit(b[i], s);
    do_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic master_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      do_bit(1'b1, s);
      d[i] = s;
    end
    do_bit(~master_ack, s);
  endtask

  task automatic push_wr(input logic [7:0] a, input logic [7:0] d);
    exp_wr.push_back({a, d});
    exp_mem[a] = d;
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    tick(5);
    check(sda_low_en == 0 && wr_en == 0 && rd_req == 0, "R11",
          {sda_low_en, wr_en, rd_req}, 0);
    rst_n = 1'b1;
    tick(10);

    for (int s = 0; s < 4; s++) begin
      addr_sel = 2'(s);
      tick(4);
      do_start();
      wbyte(waddr[s], ack);
      check(ack, "R2", ack, 1);
      wbyte(8'h10 + 8'(s), ack);
      check(ack, "R4", ack, 1);
      push_wr(8'h10 + 8'(s), 8'hC0 + 8'(s));
      wbyte(8'hC0 + 8'(s), ack);
      check(ack, "R4", ack, 1);
      do_stop();
      tick(10);
      check(sda_low_en == 0, "R1", sda_low_en, 0);
    end

    addr_sel = 2'b00;
    quiet_req = "R3";
    do_start();
    wbyte(8'h94, ack);
    check(!ack, "R3", ack, 0);
    wbyte(8'h30, ack);
    check(!ack, "R3", ack, 0);
    do_stop();
    tick(10);
    quiet_req = "R4";

    addr_sel = 2'b10;
    do_start();
    wbyte(8'h96, ack);
    wbyte(8'h20, ack);
    push_wr(8'h20, 8'hA1); wbyte(8'hA1, ack);
    push_wr(8'h21, 8'hB2); wbyte(8'hB2, ack);
    push_wr(8'h22, 8'hC3); wbyte(8'hC3, ack);
    check(ack, "R4", ack, 1);
    do_stop();
    tick(10);

    do_start();
    wbyte(8'h96, ack);
    wbyte(8'h20, ack);
    do_start();
    wbyte(8'h97, ack);
    check(ack, "R7", ack, 1);
    rbyte(1'b1, d);
    check(d == exp_mem[8'h20], "R5", d, exp_mem[8'h20]);
    rbyte(1'b1, d);
    check(d == exp_mem[8'h21], "R6", d, exp_mem[8'h21]);
    rbyte(1'b0, d);
    check(d == exp_mem[8'h22], "R5", d, exp_mem[8'h22]);
    tick(Q);
    check(sda_low_en == 0, "R6", sda_low_en, 0);
    do_stop();
    tick(10);

    do_start();
    wbyte(8'h97, ack);
    check(ack, "R2", ack, 1);
    rbyte(1'b0, d);
    check(d == exp_mem[8'h23], "R5", d, exp_mem[8'h23]);
    do_stop();
    tick(10);

    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
    wbyte(8'h96, ack);
    check(ack, "R8", ack, 1);
    wbyte(8'h40, ack);
    push_wr(8'h40, 8'h77);
    wbyte(8'h77, ack);
    check(ack, "R8", ack, 1);
    do_stop();
    tick(10);

    quiet_req = "R9";
    do_start();
    wbyte(8'h96, ack);
    wbyte(8'h50, ack);
    for (int i = 0; i < 4; i++) begin
      logic s;
      do_bit(1'b1, s);
    end
    do_stop();
    tick(Q);
    scl_m = 1'b0; tick(Q);
    wbyte(8'h11, ack);
    check(!ack, "R9", ack, 0);
    wbyte(8'h22, ack);
    check(!ack, "R9", ack, 0);
    scl_m = 1'b1; tick(Q);
    tick(20);

    check(exp_wr.size() == 0, "R4", exp_wr.size(), 0);
    check(r10_viol == 0, "R10", r10_viol, 0);
    check(mem[8'h40] == 8'h77, "R8", mem[8'h40], 8'h77);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule